// File: doc/BRIEF.md
# Masked Packed 64-bit Subtract Unit

This block subtracts a second vector operand from a first one in independent 64-bit lanes, over a result that can be as wide as eight lanes (512 bits). A length select picks how many low lanes take part. The lanes above that count either keep the prior destination value or are cleared, depending on the write mode. Two write modes apply a per-lane mask. A lane whose mask bit is clear either keeps its old value or is forced to zero. A broadcast control replaces every lane of the second operand with its low 64 bits.

Operands arrive on a valid/ready input and leave on a valid/ready output through a single register stage. A transfer is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or its content is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operands are accepted. A parameter can remove the stage, which makes the path combinational. The block raises no status flags, and the same arithmetic serves signed and unsigned data.

Top module: `vsq_unit`

## Requirements
- R1: Each active lane yields (first lane minus second lane) modulo 2^64. A borrow does not cross into the next lane, and no flag is produced.
- R2: `vlen_sel` sets the active lane count: 00 gives 1 lane (bits 63:0), 01 gives 2 lanes, 10 gives 4 lanes, 11 gives 8 lanes. Lane j occupies bits 64j+63:64j.
- R3: In `mode_sel` 00 (legacy keep), every active lane is written and every inactive lane keeps its `dst_old` value.
- R4: In `mode_sel` 01 (zero-extend), every active lane is written whatever `lane_mask` holds, and every inactive lane is zero.
- R5: In `mode_sel` 10 (masked merge), an active lane j is written when `lane_mask[j]` is 1 and keeps its `dst_old` value when it is 0. Inactive lanes are zero.
- R6: In `mode_sel` 11 (masked zero), an active lane j is written when `lane_mask[j]` is 1 and is zero when it is 0. Inactive lanes are zero.
- R7: Mask bits for lanes at or above the active lane count have no effect on the result.
- R8: When `bcast` is 1, bits 63:0 of `src_b` are subtracted in every lane, in place of that lane's own slice.
- R9: A transfer is taken when `in_valid` and `in_ready` are both high. `in_ready` equals (not `out_valid`) or `out_ready`. The result appears with `out_valid` one cycle after acceptance and stays stable while `out_ready` is low.
- R10: A synchronous active-high `rst` clears `out_valid` and `dst_new` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Unit can take an operand set |
| src_a | input | 512 | Minuend vector |
| src_b | input | 512 | Subtrahend vector; bits 63:0 are the scalar when broadcasting |
| dst_old | input | 512 | Prior destination value |
| lane_mask | input | 8 | Per-lane write mask |
| vlen_sel | input | 2 | Active length select |
| mode_sel | input | 2 | Write mode select |
| bcast | input | 1 | Broadcast low 64 bits of src_b |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result |
| dst_new | output | 512 | New destination value |

## Verification
On every accepted transfer, the assertions check the lane-level write policy. Inactive lanes must keep the old value in legacy mode and be zero otherwise. Masked-off active lanes must merge or clear according to the mode. A stalled output must hold its value. The arithmetic itself is shown only by the bench's scenarios: wrap-around at the 64-bit boundary, broadcast of the scalar, every length select, mask bits beyond the active count, and reset. The same applies to the hand-off that takes a held result and accepts a new set in the same cycle.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_ZEXT  = 2'b01,
    MODE_MERGE = 2'b10,
    MODE_MZERO = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    LANE_CALC  = 2'b00,
    LANE_OLD   = 2'b01,
    LANE_CLEAR = 2'b10
  } lane_sel_e;

endpackage

// File: rtl/vsq_policy.sv
module vsq_policy
  import vsq_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]             mask_i,
  input  logic [1:0]                   vlen_i,
  input  logic [1:0]                   mode_i,
  output lane_sel_e [LANES-1:0]        sel_o
);

  logic [31:0] act_cnt;
  wmode_e      mode;

  assign act_cnt = 32'd1 << vlen_i;
  assign mode    = wmode_e'(mode_i);

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      if (32'(j) >= act_cnt) begin
        sel_o[j] = (mode == MODE_KEEP) ? LANE_OLD : LANE_CLEAR;
      end else begin
        unique case (mode)
          MODE_MERGE: sel_o[j] = mask_i[j] ? LANE_CALC : LANE_OLD;
          MODE_MZERO: sel_o[j] = mask_i[j] ? LANE_CALC : LANE_CLEAR;
          default:    sel_o[j] = LANE_CALC;
        endcase
      end
    end
  end

endmodule

// File: rtl/vsq_lane.sv
module vsq_lane
  import vsq_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] old_i,
  input  lane_sel_e    sel_i,
  output logic [W-1:0] res_o
);

  logic [W-1:0] diff;

  // Wraps modulo 2^W; the borrow is simply dropped.
  assign diff = a_i - b_i;

  always_comb begin
    unique case (sel_i)
      LANE_CALC:  res_o = diff;
      LANE_OLD:   res_o = old_i;
      default:    res_o = '0;
    endcase
  end

endmodule

// File: rtl/vsq_unit.sv
module vsq_unit
  import vsq_pkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int LANES     = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANE_W*LANES-1:0]   src_a,
  input  logic [LANE_W*LANES-1:0]   src_b,
  input  logic [LANE_W*LANES-1:0]   dst_old,
  input  logic [LANES-1:0]          lane_mask,
  input  logic [1:0]                vlen_sel,
  input  logic [1:0]                mode_sel,
  input  logic                      bcast,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANE_W*LANES-1:0]   dst_new
);

  localparam int VEC_W = LANE_W * LANES;

  lane_sel_e [LANES-1:0] lane_sel;
  logic [VEC_W-1:0]      comb_res;
  logic                  fire;

  assign fire = in_valid && in_ready;

  vsq_policy #(.LANES(LANES)) u_policy (
    .mask_i (lane_mask),
    .vlen_i (vlen_sel),
    .mode_i (mode_sel),
    .sel_o  (lane_sel)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] b_eff;
    assign b_eff = bcast ? src_b[LANE_W-1:0] : src_b[j*LANE_W +: LANE_W];

    vsq_lane #(.W(LANE_W)) u_lane (
      .a_i   (src_a[j*LANE_W +: LANE_W]),
      .b_i   (b_eff),
      .old_i (dst_old[j*LANE_W +: LANE_W]),
      .sel_i (lane_sel[j]),
      .res_o (comb_res[j*LANE_W +: LANE_W])
    );
  end

  if (REGISTERED) begin : g_reg
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        dst_new   <= '0;
      end else begin
        if (fire) begin
          out_valid <= 1'b1;
          dst_new   <= comb_res;
        end else if (out_ready) begin
          out_valid <= 1'b0;
        end
      end
    end

    // R9: a stalled result stays put
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(dst_new)));

    for (genvar j = 0; j < LANES; j++) begin : g_chk
      logic lane_off;
      assign lane_off = (32'(j) >= (32'd1 << vlen_sel));

      p_keep_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_sel == 2'b00 && lane_off)
        |=> dst_new[j*LANE_W +: LANE_W] == $past(dst_old[j*LANE_W +: LANE_W]));

      p_clear_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_sel != 2'b00 && lane_off)
        |=> dst_new[j*LANE_W +: LANE_W] == '0);

      p_merge_off_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_sel == 2'b10 && !lane_off && !lane_mask[j])
        |=> dst_new[j*LANE_W +: LANE_W] == $past(dst_old[j*LANE_W +: LANE_W]));

      p_zero_off_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_sel == 2'b11 && !lane_off && !lane_mask[j])
        |=> dst_new[j*LANE_W +: LANE_W] == '0);
    end
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign dst_new   = comb_res;
  end

endmodule

// File: tb/tb_vsq_unit.sv
module tb_vsq_unit;

  localparam int W = 64;
  localparam int N = 8;
  localparam int VW = W * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [N-1:0]  lane_mask = '0;
  logic [1:0]    vlen_sel = 2'b00, mode_sel = 2'b00;
  logic          bcast = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] dst_new;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vsq_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .lane_mask(lane_mask),
    .vlen_sel(vlen_sel), .mode_sel(mode_sel), .bcast(bcast),
    .out_valid(out_valid), .out_ready(out_ready), .dst_new(dst_new)
  );

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] pat(input logic [63:0] seed);
    logic [VW-1:0] v;
    for (int k = 0; k < N; k++)
      v[k*W +: W] = (64'h0123_4567_89AB_CDEF * 64'(k + 3)) ^ seed;
    return v;
  endfunction

  // Reference from the requirements text.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, b, old,
                                           input logic [N-1:0] m, input logic [1:0] vl,
                                           input logic [1:0] md, input logic bc);
    logic [VW-1:0] r;
    int act;
    act = 1 << vl;
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] sb, d;
      sb = bc ? b[W-1:0] : b[k*W +: W];
      d  = a[k*W +: W] - sb;
      if (k >= act) r[k*W +: W] = (md == 2'b00) ? old[k*W +: W] : '0;
      else if (md == 2'b10) r[k*W +: W] = m[k] ? d : old[k*W +: W];
      else if (md == 2'b11) r[k*W +: W] = m[k] ? d : '0;
      else r[k*W +: W] = d;
    end
    return r;
  endfunction

  task automatic xfer(input logic [VW-1:0] a, b, old, input logic [N-1:0] m,
                      input logic [1:0] vl, md, input logic bc, output logic [VW-1:0] got);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = old; lane_mask = m;
    vlen_sel = vl; mode_sel = md; bcast = bc;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = dst_new;
    n_run++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 out_valid actual=%b expected=1", out_valid);
    end
  endtask

  task automatic t_reset();
    logic [VW-1:0] got;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 dst_new after reset", dst_new, '0);
    chk("R10 out_valid after reset", {511'd0, out_valid}, '0);
    rst = 1'b0;
    xfer(pat(64'h11), pat(64'h22), pat(64'h33), 8'hFF, 2'b11, 2'b01, 1'b0, got);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-run reset clears result", dst_new, '0);
    rst = 1'b0;
  endtask

  task automatic t_wrap();
    logic [VW-1:0] a, b, got, exp;
    a = '0; b = '0;
    a[63:0]   = 64'd0;                  b[63:0]   = 64'd1;
    a[127:64] = 64'h8000_0000_0000_0000; b[127:64] = 64'd1;
    exp = '0;
    exp[63:0]   = 64'hFFFF_FFFF_FFFF_FFFF;
    exp[127:64] = 64'h7FFF_FFFF_FFFF_FFFF;
    xfer(a, b, pat(64'h5), 8'h00, 2'b01, 2'b01, 1'b0, got);
    chk("R1 wrap no borrow across lanes", got, exp);
    xfer(pat(64'hA5), pat(64'h3C), pat(64'h77), 8'h00, 2'b11, 2'b01, 1'b0, got);
    chk("R1 full-width subtract", got, model(pat(64'hA5), pat(64'h3C), pat(64'h77), 8'h00, 2'b11, 2'b01, 1'b0));
  endtask

  task automatic t_lengths();
    logic [VW-1:0] got;
    for (int v = 0; v < 4; v++) begin
      xfer(pat(64'h1234), pat(64'h9876), pat(64'hDEAD), 8'hFF, 2'(v), 2'b01, 1'b0, got);
      chk($sformatf("R2 length select %0d", v), got,
          model(pat(64'h1234), pat(64'h9876), pat(64'hDEAD), 8'hFF, 2'(v), 2'b01, 1'b0));
    end
  endtask

  task automatic t_legacy();
    logic [VW-1:0] got, old;
    old = pat(64'hFACE);
    xfer(pat(64'h1), pat(64'h2), old, 8'h00, 2'b01, 2'b00, 1'b0, got);
    chk("R3 legacy 128 keeps upper", got[VW-1:128], old[VW-1:128]);
    xfer(pat(64'h1), pat(64'h2), old, 8'h00, 2'b00, 2'b00, 1'b0, got);
    chk("R3 legacy 64", got, model(pat(64'h1), pat(64'h2), old, 8'h00, 2'b00, 2'b00, 1'b0));
  endtask

  task automatic t_zext();
    logic [VW-1:0] got;
    xfer(pat(64'h9), pat(64'h4), pat(64'hBEEF), 8'h00, 2'b10, 2'b01, 1'b0, got);
    chk("R4 zero-extend 256 mask ignored", got,
        model(pat(64'h9), pat(64'h4), pat(64'hBEEF), 8'hFF, 2'b10, 2'b01, 1'b0));
  endtask

  task automatic t_merge();
    logic [VW-1:0] got;
    xfer(pat(64'h71), pat(64'h17), pat(64'hC0DE), 8'b1010_0110, 2'b11, 2'b10, 1'b0, got);
    chk("R5 masked merge 512", got,
        model(pat(64'h71), pat(64'h17), pat(64'hC0DE), 8'b1010_0110, 2'b11, 2'b10, 1'b0));
    xfer(pat(64'h71), pat(64'h17), pat(64'hC0DE), 8'b0000_0101, 2'b10, 2'b10, 1'b0, got);
    chk("R5 masked merge 256", got,
        model(pat(64'h71), pat(64'h17), pat(64'hC0DE), 8'b0000_0101, 2'b10, 2'b10, 1'b0));
  endtask

  task automatic t_mzero();
    logic [VW-1:0] got;
    xfer(pat(64'h3), pat(64'hF0), pat(64'h44), 8'b0101_1001, 2'b11, 2'b11, 1'b0, got);
    chk("R6 masked zero 512", got,
        model(pat(64'h3), pat(64'hF0), pat(64'h44), 8'b0101_1001, 2'b11, 2'b11, 1'b0));
  endtask

  task automatic t_mask_ignored();
    logic [VW-1:0] got_a, got_b;
    xfer(pat(64'h8), pat(64'h6), pat(64'h55), 8'b0000_0010, 2'b01, 2'b10, 1'b0, got_a);
    xfer(pat(64'h8), pat(64'h6), pat(64'h55), 8'b1111_1110, 2'b01, 2'b10, 1'b0, got_b);
    chk("R7 upper mask bits ignored", got_b, got_a);
    chk("R7 upper lanes zero", got_b[VW-1:128], '0);
  endtask

  task automatic t_bcast();
    logic [VW-1:0] got, exp;
    xfer(pat(64'h2222), pat(64'h6), pat(64'h0), 8'hFF, 2'b11, 2'b01, 1'b1, got);
    for (int k = 0; k < N; k++)
      exp[k*W +: W] = pat(64'h2222) >> (k*W) - pat(64'h6) & 0 | 64'(pat(64'h2222) >> (k*W)) - pat(64'h6)[W-1:0];
    chk("R8 broadcast scalar", got, exp);
    xfer(pat(64'h2222), pat(64'h6), pat(64'h0), 8'b0011_0011, 2'b10, 2'b11, 1'b1, got);
    chk("R8 broadcast with mask", got,
        model(pat(64'h2222), pat(64'h6), pat(64'h0), 8'b0011_0011, 2'b10, 2'b11, 1'b1));
  endtask

  task automatic t_backpressure();
    logic [VW-1:0] first, second;
    first  = model(pat(64'hAB), pat(64'hCD), '0, 8'hFF, 2'b11, 2'b01, 1'b0);
    second = model(pat(64'h01), pat(64'h02), '0, 8'hFF, 2'b11, 2'b01, 1'b0);
    @(negedge clk);
    src_a = pat(64'hAB); src_b = pat(64'hCD); dst_old = '0; lane_mask = 8'hFF;
    vlen_sel = 2'b11; mode_sel = 2'b01; bcast = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    src_a = pat(64'h01); src_b = pat(64'h02);
    chk("R9 in_ready low when full and stalled", {511'd0, in_ready}, '0);
    repeat (2) @(negedge clk);
    chk("R9 result held under stall", dst_new, first);
    chk("R9 out_valid held", {511'd0, out_valid}, {511'd0, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 hand-off accepts next set", dst_new, second);
    @(negedge clk);
    chk("R9 out_valid drops when drained", {511'd0, out_valid}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_wrap();
    t_lengths();
    t_legacy();
    t_zext();
    t_merge();
    t_mzero();
    t_mask_ignored();
    t_bcast();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule